// File: doc/BRIEF.md
# Exception Status Return Controller

This block holds the exception control state of a small processor core. It keeps a live status word and two saved copies of it. The live word has an interrupt-enable bit, a non-maskable mode bit and a register-set selector. One saved copy receives the live status when an exception is handled in the same register set. The other receives it when the exception moves execution into a different register set. For each register set the block also keeps an exception return address, and a flag that records whether the exception was a hardware interrupt.

When the exception-entry strobe arrives, the block saves the status and the return address and switches the live status to the handler context. When the return strobe arrives, it picks the saved copy named by the current register-set selector and restores the live status from it. The restore can only clear the non-maskable mode bit, never set it. One cycle later the block emits a redirect address. The block also gates maskable interrupt requests with the enable bit. A software write strobe sets the enable bit and the non-maskable mode bit directly.

Top module: `exc_ret_ctrl`

## Requirements
- R1: After reset, pie_o, nmi_o, crs_o, redirect_valid_o and irq_take_o are all 0.
- R2: The cycle after an accepted entry, pie_o is 0 and crs_o equals entry_set_i. nmi_o becomes 1 if entry_nmi_i was 1 and otherwise keeps its value.
- R3: On entry, the live status is saved into the normal copy when entry_set_i equals the current crs_o, and into the shadow copy otherwise. The copy that is not selected keeps its value.
- R4: On a return with crs_o equal to 0, pie_o and crs_o are reloaded from the normal saved copy.
- R5: On a return with crs_o not equal to 0, pie_o and crs_o are reloaded from the shadow saved copy.
- R6: After a return, nmi_o is the AND of its previous value and the saved bit. A return can clear the mode but never set it.
- R7: One cycle after an accepted return, redirect_valid_o is 1 for exactly one cycle. For an instruction-related entry, redirect_pc_o is entry_pc_i + 4 as saved for the register set that crs_o named before the return.
- R8: If the entry saved for that register set had entry_hw_i = 1, redirect_pc_o is the saved address minus 4, which equals the interrupted entry_pc_i.
- R9: irq_take_o equals irq_req_i AND pie_o, combinationally.
- R10: If entry_i and ret_i are high in the same cycle, the entry is performed and the return is dropped: redirect_valid_o stays 0.
- R11: A status write (stat_wr_i), when neither strobe is present, loads pie_o and nmi_o from stat_wr_pie_i and stat_wr_nmi_i on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_i | input | 1 | Exception entry strobe, single cycle |
| entry_set_i | input | 6 | Register set of the handler |
| entry_nmi_i | input | 1 | Entry is non-maskable |
| entry_hw_i | input | 1 | Entry is a hardware interrupt (1) or instruction-related (0) |
| entry_pc_i | input | 32 | Address of the excepting or interrupted instruction |
| ret_i | input | 1 | Exception return strobe, single cycle |
| stat_wr_i | input | 1 | Software status write strobe |
| stat_wr_pie_i | input | 1 | Enable value to write |
| stat_wr_nmi_i | input | 1 | Mode value to write |
| irq_req_i | input | 1 | Maskable interrupt request |
| irq_take_o | output | 1 | Request accepted under current enable |
| pie_o | output | 1 | Live interrupt enable |
| nmi_o | output | 1 | Live non-maskable mode |
| crs_o | output | 6 | Live register-set selector |
| redirect_valid_o | output | 1 | Redirect address valid pulse |
| redirect_pc_o | output | 32 | Redirect address after return |

## Verification
Returns are driven from selector 0 and from a nonzero selector. The saved copies are filled with different enable and selector values, so restoring from the wrong copy shows up in pie_o or crs_o. A nested same-set entry inside a set-changing one checks that the shadow copy is left alone. Separate scenarios cover the mode bit: one where the saved bit is 0 and the live bit is 1, and one where the saved bit is 1 and the live bit is 0. Together they separate AND from copy. Hardware and instruction entries into the same register set are compared to show the minus-4 rule, and a simultaneous entry and return exposes the priority order.

// File: rtl/exc_ret_pkg.sv
package exc_ret_pkg;
  parameter int CRS_W      = 6;
  parameter int ADDR_W     = 32;
  parameter int INSN_BYTES = 4;

  typedef struct packed {
    logic [CRS_W-1:0] crs;
    logic             nmi;
    logic             pie;
  } stat_t;

  // address saved on entry: the instruction after the one that excepted
  function automatic logic [ADDR_W-1:0] save_addr(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(INSN_BYTES);
  endfunction

  // address resumed on return: interrupts re-run the interrupted instruction
  function automatic logic [ADDR_W-1:0] resume_addr(input logic [ADDR_W-1:0] ea,
                                                    input logic hw);
    return hw ? (ea - ADDR_W'(INSN_BYTES)) : ea;
  endfunction

  // restore: take the saved word, but the mode bit may only fall
  function automatic stat_t restore_stat(input stat_t live, input stat_t src);
    stat_t r;
    r     = src;
    r.nmi = live.nmi & src.nmi;
    return r;
  endfunction
endpackage

// File: rtl/exc_status_regs.sv
module exc_status_regs
  import exc_ret_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry_fire,
  input  logic [CRS_W-1:0] entry_set,
  input  logic             entry_nmi,
  input  logic             ret_fire,
  input  logic             wr_fire,
  input  logic             wr_pie,
  input  logic             wr_nmi,
  output stat_t            live,
  output logic             set_change
);
  stat_t est_q, sst_q, restore_src, restored;

  assign set_change  = (entry_set != live.crs);
  assign restore_src = (live.crs == '0) ? est_q : sst_q;
  assign restored    = restore_stat(live, restore_src);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live  <= '0;
      est_q <= '0;
      sst_q <= '0;
    end else if (entry_fire) begin
      if (set_change) sst_q <= live;
      else            est_q <= live;
      live.pie <= 1'b0;
      live.nmi <= live.nmi | entry_nmi;
      live.crs <= entry_set;
    end else if (ret_fire) begin
      live <= restored;
    end else if (wr_fire) begin
      live.pie <= wr_pie;
      live.nmi <= wr_nmi;
    end
  end

  p_pie_off_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    entry_fire |=> !live.pie);
  p_crs_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    entry_fire |=> live.crs == $past(entry_set));
  p_shadow_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    entry_fire && !set_change |=> $stable(sst_q));
  p_normal_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    entry_fire && set_change |=> $stable(est_q));
  p_nmi_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire && !live.nmi |=> !live.nmi);
endmodule

// File: rtl/exc_addr_bank.sv
module exc_addr_bank
  import exc_ret_pkg::*;
#(
  parameter int NUM_SETS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CRS_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_pc,
  input  logic              wr_hw,
  input  logic [CRS_W-1:0]  rd_sel,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hw
);
  logic [ADDR_W-1:0] ea_q [NUM_SETS];
  logic              hw_q [NUM_SETS];

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ea_q[g] <= '0;
        hw_q[g] <= 1'b0;
      end else if (wr_en && wr_sel == CRS_W'(g)) begin
        ea_q[g] <= save_addr(wr_pc);
        hw_q[g] <= wr_hw;
      end
    end
  end

  always_comb begin
    rd_addr = '0;
    rd_hw   = 1'b0;
    for (int i = 0; i < NUM_SETS; i++) begin
      if (rd_sel == CRS_W'(i)) begin
        rd_addr = ea_q[i];
        rd_hw   = hw_q[i];
      end
    end
  end
endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
  import exc_ret_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_fire,
  input  logic [ADDR_W-1:0] ea,
  input  logic              hw,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_pc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      redirect_valid <= ret_fire;
      if (ret_fire) redirect_pc <= resume_addr(ea, hw);
    end
  end

  p_redir_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> $past(ret_fire));
endmodule

// File: rtl/exc_ret_ctrl.sv
module exc_ret_ctrl
  import exc_ret_pkg::*;
#(
  parameter int NUM_SETS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_i,
  input  logic [CRS_W-1:0]  entry_set_i,
  input  logic              entry_nmi_i,
  input  logic              entry_hw_i,
  input  logic [ADDR_W-1:0] entry_pc_i,
  input  logic              ret_i,
  input  logic              stat_wr_i,
  input  logic              stat_wr_pie_i,
  input  logic              stat_wr_nmi_i,
  input  logic              irq_req_i,
  output logic              irq_take_o,
  output logic              pie_o,
  output logic              nmi_o,
  output logic [CRS_W-1:0]  crs_o,
  output logic              redirect_valid_o,
  output logic [ADDR_W-1:0] redirect_pc_o
);
  // priority: entry over return over software write
  logic ret_fire, wr_fire, set_change, ea_hw;
  logic [ADDR_W-1:0] ea_rd;
  stat_t live;

  assign ret_fire = ret_i & ~entry_i;
  assign wr_fire  = stat_wr_i & ~entry_i & ~ret_i;

  exc_status_regs u_stat (
    .clk(clk), .rst_n(rst_n),
    .entry_fire(entry_i), .entry_set(entry_set_i), .entry_nmi(entry_nmi_i),
    .ret_fire(ret_fire),
    .wr_fire(wr_fire), .wr_pie(stat_wr_pie_i), .wr_nmi(stat_wr_nmi_i),
    .live(live), .set_change(set_change)
  );

  exc_addr_bank #(.NUM_SETS(NUM_SETS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(entry_i), .wr_sel(entry_set_i), .wr_pc(entry_pc_i), .wr_hw(entry_hw_i),
    .rd_sel(live.crs), .rd_addr(ea_rd), .rd_hw(ea_hw)
  );

  exc_redirect u_redir (
    .clk(clk), .rst_n(rst_n),
    .ret_fire(ret_fire), .ea(ea_rd), .hw(ea_hw),
    .redirect_valid(redirect_valid_o), .redirect_pc(redirect_pc_o)
  );

  assign pie_o      = live.pie;
  assign nmi_o      = live.nmi;
  assign crs_o      = live.crs;
  assign irq_take_o = irq_req_i & live.pie;

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pie_o |-> !irq_take_o);
  p_entry_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    entry_i && ret_i |=> !redirect_valid_o);
  p_redir_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o && !$past(ret_i) |-> 1'b0);
  p_set_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    entry_i && set_change |=> crs_o != $past(crs_o));
endmodule

// File: tb/exc_ret_ctrl_tb.sv
module exc_ret_ctrl_tb;
  logic        clk = 0;
  logic        rst_n;
  logic        entry_i, entry_nmi_i, entry_hw_i, ret_i;
  logic [5:0]  entry_set_i;
  logic [31:0] entry_pc_i;
  logic        stat_wr_i, stat_wr_pie_i, stat_wr_nmi_i, irq_req_i;
  logic        irq_take_o, pie_o, nmi_o, redirect_valid_o;
  logic [5:0]  crs_o;
  logic [31:0] redirect_pc_o;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  exc_ret_ctrl u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    entry_i = 0; ret_i = 0; stat_wr_i = 0;
  endtask

  task automatic do_entry(logic [5:0] set, logic nmi, logic hw, logic [31:0] pc);
    @(negedge clk);
    entry_i = 1; entry_set_i = set; entry_nmi_i = nmi; entry_hw_i = hw; entry_pc_i = pc;
    @(negedge clk); idle();
  endtask

  task automatic do_write(logic pie, logic nmi);
    @(negedge clk);
    stat_wr_i = 1; stat_wr_pie_i = pie; stat_wr_nmi_i = nmi;
    @(negedge clk); idle();
  endtask

  // return; on exit the redirect pulse is visible
  task automatic do_ret();
    @(negedge clk); ret_i = 1;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    irq_req_i = 1; #1;
    check("R1 pie", pie_o, 0); check("R1 nmi", nmi_o, 0);
    check("R1 crs", crs_o, 0); check("R1 redirect", redirect_valid_o, 0);
    check("R1 take", irq_take_o, 0);
  endtask

  task automatic t_gate();
    do_write(1, 0);
    check("R11 pie", pie_o, 1); check("R11 nmi", nmi_o, 0);
    irq_req_i = 1; #1; check("R9 take", irq_take_o, 1);
    irq_req_i = 0; #1; check("R9 noreq", irq_take_o, 0);
  endtask

  task automatic t_same_set();
    do_entry(0, 0, 0, 32'h100);
    check("R2 pie", pie_o, 0); check("R2 crs", crs_o, 0);
    irq_req_i = 1; #1; check("R9 masked", irq_take_o, 0); irq_req_i = 0;
    do_ret();
    check("R7 valid", redirect_valid_o, 1); check("R7 pc", redirect_pc_o, 32'h104);
    check("R4 pie", pie_o, 1); check("R4 crs", crs_o, 0);
    @(negedge clk); check("R7 one pulse", redirect_valid_o, 0);
  endtask

  task automatic t_switch();
    do_entry(2, 0, 1, 32'h200);
    check("R2 crs2", crs_o, 2); check("R2 pie0", pie_o, 0);
    do_entry(2, 0, 0, 32'h240);   // nested same set: shadow copy untouched
    do_ret();
    check("R5 crs", crs_o, 0); check("R3 R5 pie", pie_o, 1);
    check("R7 pc set2", redirect_pc_o, 32'h244);
    do_entry(2, 0, 1, 32'h200);
    do_ret();
    check("R8 hw pc", redirect_pc_o, 32'h200); check("R5 crs back", crs_o, 0);
  endtask

  task automatic t_nmi_clear();
    do_entry(0, 1, 0, 32'h300);
    check("R2 nmi set", nmi_o, 1); check("R2 pie", pie_o, 0);
    do_ret();
    check("R6 nmi cleared", nmi_o, 0); check("R4 pie", pie_o, 1);
    check("R7 pc", redirect_pc_o, 32'h304);
  endtask

  task automatic t_nmi_noset();
    do_entry(0, 1, 0, 32'h400);
    do_entry(1, 0, 0, 32'h500);
    check("R2 nmi kept", nmi_o, 1); check("R2 crs1", crs_o, 1);
    do_write(0, 0);
    check("R11 nmi0", nmi_o, 0);
    do_ret();
    check("R6 no set", nmi_o, 0); check("R5 crs0", crs_o, 0);
    check("R5 pie0", pie_o, 0); check("R7 pc set1", redirect_pc_o, 32'h504);
  endtask

  task automatic t_both();
    do_write(1, 0);
    @(negedge clk);
    entry_i = 1; ret_i = 1; entry_set_i = 3; entry_nmi_i = 0; entry_hw_i = 0;
    entry_pc_i = 32'h600;
    @(negedge clk); idle();
    check("R10 no redirect", redirect_valid_o, 0);
    check("R10 crs", crs_o, 3); check("R10 pie", pie_o, 0);
    do_ret();
    check("R10 later ret", redirect_pc_o, 32'h604); check("R5 pie", pie_o, 1);
  endtask

  initial begin
    idle(); irq_req_i = 0; entry_set_i = 0; entry_nmi_i = 0; entry_hw_i = 0;
    entry_pc_i = 0; stat_wr_pie_i = 0; stat_wr_nmi_i = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_gate(); t_same_set(); t_switch(); t_nmi_clear(); t_nmi_noset(); t_both();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule